// File: doc/BRIEF.md
# Matmul Phase Sequencer

This block is the control sequencer for one pass of a 4×4 weight-stationary multiply-accumulate grid. It waits in an idle state until a start pulse arrives. It then moves through three timed phases. In the first phase, one column of stationary weights is written per cycle. In the second, skewed activation rows enter along the west edge. In the third, the last partial sums move out along the south edge. After the third phase it raises a completion flag for one cycle and goes back to idle.

The sequencer drives every enable the grid and its result buffer need. These are the weight write enable with its column index, a per-row activation enable that applies the diagonal skew, and a per-column capture strobe for the south-edge results. Each capture strobe fires in the cycle that the column's final sum arrives. The current phase is always visible on a debug output. The phase lengths come from the grid dimension `ARR_N`: `ARR_N`, `2*ARR_N-1` and `ARR_N-1` cycles. With the default of 4, these make a fixed 14-cycle budget.

Top module: `mm_phase_seq`

## Requirements
- R1: While reset is held and in the cycle after it is released, the phase is idle (code 0) and done is low. All weight, activation and capture outputs are zero in that cycle.
- R2: A start that is high in an idle cycle puts the block into the weight-load phase in the next cycle. A start seen in any other phase, including the done cycle, does not change the sequence.
- R3: The weight-load phase lasts 4 cycles. Throughout it, the weight enable is high, and the column index takes the values 0, 1, 2, 3 in turn.
- R4: The stream phase lasts 7 cycles. The step output counts 0 to 6 in that phase and reads 0 at all other times. In step s, activation enable bit r is high only when r ≤ s ≤ r+3.
- R5: The drain phase lasts exactly 3 cycles and comes straight after the stream phase.
- R6: The done flag is high in the single cycle after the 14 working cycles, which is 15 cycles after start was sampled, and the phase reads 4 in that cycle. The block is idle again in the next cycle.
- R7: Let global step g count from 0 at the first stream cycle. Capture strobe bit c is high exactly when g = 6 + c. This puts bit 0 on the last stream cycle and bits 1 to 3 on the three drain cycles, and at most one bit is high in any cycle.
- R8: The phase output codes are: idle 0, weight load 1, stream 2, drain 3, done 4.
- R9: Outside the weight-load phase, the weight enable and the column index are zero. Outside the stream phase, all activation enables are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begins a multiply when seen in idle |
| phase_o | output | 3 | Current phase code (debug) |
| wload_en | output | 1 | Weight column write enable |
| wload_col | output | 2 | Weight column index |
| stream_step | output | 3 | Cycle index within the stream phase |
| act_en | output | 4 | Per-row activation injection enable |
| cap_strb | output | 4 | Per-column result capture strobe |
| done | output | 1 | One-cycle completion flag |

## Verification
The assertions check local rules on every cycle. These rules are the start handshake out of idle, the column index stepping during weight load, drain following stream only, done lasting a single cycle and returning to idle, and weight and activation enables staying inside their own phase. At most one capture strobe may be high in any cycle. The bench scenarios cover what cycle-local rules cannot: the exact placement of every enable and strobe within the 14-cycle budget, the triangular skew pattern, and the sequence staying unchanged when start is held or toggled in mid-run and in the done cycle.

// File: rtl/mm_seq_pkg.sv
package mm_seq_pkg;

    typedef enum logic [2:0] {
        PH_IDLE   = 3'd0,
        PH_WLOAD  = 3'd1,
        PH_STREAM = 3'd2,
        PH_DRAIN  = 3'd3,
        PH_DONE   = 3'd4
    } phase_e;

    function automatic int wload_len(input int n);
        return n;
    endfunction

    function automatic int stream_len(input int n);
        return 2 * n - 1;
    endfunction

    function automatic int drain_len(input int n);
        return n - 1;
    endfunction

    function automatic int step_w(input int n);
        return $clog2(2 * n - 1);
    endfunction

endpackage

// File: rtl/mm_phase_fsm.sv
module mm_phase_fsm
    import mm_seq_pkg::*;
#(
    parameter int ARR_N = 4,
    localparam int SW = step_w(ARR_N)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    output phase_e        phase_q,
    output logic [SW-1:0] cnt_q
);
    localparam logic [SW-1:0] WL_LAST = SW'(wload_len(ARR_N) - 1);
    localparam logic [SW-1:0] ST_LAST = SW'(stream_len(ARR_N) - 1);
    localparam logic [SW-1:0] DR_LAST = SW'(drain_len(ARR_N) - 1);

    phase_e phase_d;

    always_comb begin
        phase_d = phase_q;
        unique case (phase_q)
            PH_IDLE:   if (start)            phase_d = PH_WLOAD;
            PH_WLOAD:  if (cnt_q == WL_LAST) phase_d = PH_STREAM;
            PH_STREAM: if (cnt_q == ST_LAST) phase_d = PH_DRAIN;
            PH_DRAIN:  if (cnt_q == DR_LAST) phase_d = PH_DONE;
            PH_DONE:                         phase_d = PH_IDLE;
            default:                         phase_d = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_IDLE;
            cnt_q   <= '0;
        end else begin
            phase_q <= phase_d;
            cnt_q   <= (phase_d != phase_q) ? '0 : cnt_q + 1'b1;
        end
    end

    // R2
    start_take_chk: assert property (@(posedge clk) disable iff (rst)
        (phase_q == PH_IDLE && start) |=> phase_q == PH_WLOAD);

    // R2
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (phase_q == PH_IDLE && !start) |=> phase_q == PH_IDLE);

    // R5
    drain_entry_chk: assert property (@(posedge clk) disable iff (rst)
        (phase_q == PH_DRAIN && cnt_q == '0) |-> $past(phase_q) == PH_STREAM);

endmodule

// File: rtl/mm_skew_gen.sv
module mm_skew_gen
    import mm_seq_pkg::*;
#(
    parameter int ARR_N = 4,
    localparam int SW = step_w(ARR_N)
) (
    input  phase_e           phase,
    input  logic [SW-1:0]    cnt,
    output logic [SW-1:0]    step,
    output logic [ARR_N-1:0] row_en
);
    logic streaming;
    assign streaming = (phase == PH_STREAM);
    assign step      = streaming ? cnt : '0;

    for (genvar r = 0; r < ARR_N; r++) begin : g_row
        assign row_en[r] = streaming && (int'(cnt) >= r) && (int'(cnt) <= r + ARR_N - 1);
    end

endmodule

// File: rtl/mm_capture_gen.sv
module mm_capture_gen
    import mm_seq_pkg::*;
#(
    parameter int ARR_N = 4,
    localparam int SW = step_w(ARR_N)
) (
    input  logic             clk,
    input  logic             rst,
    input  phase_e           phase,
    input  logic [SW-1:0]    cnt,
    output logic [ARR_N-1:0] col_strb
);
    localparam int GW = SW + 1;

    logic          active;
    logic [GW-1:0] gstep;

    assign active = (phase == PH_STREAM) || (phase == PH_DRAIN);
    assign gstep  = (phase == PH_DRAIN) ? GW'(stream_len(ARR_N)) + GW'(cnt) : GW'(cnt);

    for (genvar c = 0; c < ARR_N; c++) begin : g_col
        assign col_strb[c] = active && (gstep == GW'(2 * ARR_N - 2 + c));
    end

    // R7
    strb_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(col_strb));

    // R7
    strb_last_chk: assert property (@(posedge clk) disable iff (rst)
        col_strb[ARR_N-1] |=> phase == PH_DONE);

endmodule

// File: rtl/mm_phase_seq.sv
module mm_phase_seq
    import mm_seq_pkg::*;
#(
    parameter int ARR_N = 4,
    localparam int SW = step_w(ARR_N),
    localparam int CW = $clog2(ARR_N)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    output logic [2:0]       phase_o,
    output logic             wload_en,
    output logic [CW-1:0]    wload_col,
    output logic [SW-1:0]    stream_step,
    output logic [ARR_N-1:0] act_en,
    output logic [ARR_N-1:0] cap_strb,
    output logic             done
);
    phase_e        phase;
    logic [SW-1:0] cnt;

    mm_phase_fsm #(.ARR_N(ARR_N)) u_fsm (
        .clk     (clk),
        .rst     (rst),
        .start   (start),
        .phase_q (phase),
        .cnt_q   (cnt)
    );

    mm_skew_gen #(.ARR_N(ARR_N)) u_skew (
        .phase  (phase),
        .cnt    (cnt),
        .step   (stream_step),
        .row_en (act_en)
    );

    mm_capture_gen #(.ARR_N(ARR_N)) u_cap (
        .clk      (clk),
        .rst      (rst),
        .phase    (phase),
        .cnt      (cnt),
        .col_strb (cap_strb)
    );

    assign phase_o   = phase;
    assign wload_en  = (phase == PH_WLOAD);
    assign wload_col = wload_en ? cnt[CW-1:0] : '0;
    assign done      = (phase == PH_DONE);

    // R3
    col_step_chk: assert property (@(posedge clk) disable iff (rst)
        (wload_en && wload_col != CW'(ARR_N - 1)) |=> wload_en && wload_col == $past(wload_col) + 1'b1);

    // R6
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done && phase_o == 3'd0);

    // R9
    act_phase_chk: assert property (@(posedge clk) disable iff (rst)
        (act_en != '0) |-> phase_o == 3'd2);

    // R9
    wload_phase_chk: assert property (@(posedge clk) disable iff (rst)
        (phase_o != 3'd1) |-> (!wload_en && wload_col == '0));

endmodule

// File: tb/sim_mm_phase_seq.sv
module sim_mm_phase_seq;
    localparam int PERIOD = 10;

    typedef struct packed {
        logic [2:0] ph;
        logic       wl;
        logic [1:0] col;
        logic [2:0] step;
        logic [3:0] act;
        logic [3:0] cap;
        logic       dn;
    } snap_t;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       start = 1'b0;
    logic [2:0] phase_o;
    logic       wload_en;
    logic [1:0] wload_col;
    logic [2:0] stream_step;
    logic [3:0] act_en;
    logic [3:0] cap_strb;
    logic       done;

    int    n_vec = 0;
    int    n_bad = 0;
    logic  mon_on = 1'b0;
    logic  finished = 1'b0;
    snap_t expq[$];

    always #(PERIOD/2) clk = ~clk;

    mm_phase_seq u0 (
        .clk(clk), .rst(rst), .start(start), .phase_o(phase_o),
        .wload_en(wload_en), .wload_col(wload_col), .stream_step(stream_step),
        .act_en(act_en), .cap_strb(cap_strb), .done(done)
    );

    // expected outputs t cycles after start was driven (t=0: still idle)
    function automatic snap_t exp_at(input int t);
        snap_t e = '0;
        if (t >= 1 && t <= 4) begin
            e.ph = 3'd1; e.wl = 1'b1; e.col = 2'(t - 1);
        end else if (t >= 5 && t <= 11) begin
            e.ph = 3'd2; e.step = 3'(t - 5);
            for (int r = 0; r < 4; r++)
                e.act[r] = ((t - 5) >= r) && ((t - 5) <= r + 3);
        end else if (t >= 12 && t <= 14) begin
            e.ph = 3'd3;
        end else if (t == 15) begin
            e.ph = 3'd4; e.dn = 1'b1;
        end
        if (t >= 5 && t <= 14)
            for (int c = 0; c < 4; c++)
                e.cap[c] = ((t - 5) == 6 + c);
        return e;
    endfunction

    function automatic string ph_req(input logic [2:0] p);
        case (p)
            3'd1: return "R3";
            3'd2: return "R4";
            3'd3: return "R5";
            3'd4: return "R6";
            default: return "R2";
        endcase
    endfunction

    task automatic compare(input snap_t e);
        snap_t a;
        a = '{phase_o, wload_en, wload_col, stream_step, act_en, cap_strb, done};
        n_vec++;
        if (a.ph != e.ph) begin
            n_bad++;
            $display("FAIL %s R8 phase act=%0d exp=%0d", ph_req(e.ph), a.ph, e.ph);
        end
        if (a.wl != e.wl || a.col != e.col) begin
            n_bad++;
            $display("FAIL R3 R9 wload act=%0b/%0d exp=%0b/%0d", a.wl, a.col, e.wl, e.col);
        end
        if (a.step != e.step || a.act != e.act) begin
            n_bad++;
            $display("FAIL R4 stream act=%0d/%b exp=%0d/%b", a.step, a.act, e.step, e.act);
        end
        if (a.cap != e.cap) begin
            n_bad++;
            $display("FAIL R7 cap_strb act=%b exp=%b", a.cap, e.cap);
        end
        if (a.dn != e.dn) begin
            n_bad++;
            $display("FAIL R6 done act=%0b exp=%0b", a.dn, e.dn);
        end
    endtask

    // monitor: pops one expected item per cycle, idle when empty
    always @(negedge clk) begin
        if (mon_on) begin
            #1;
            if (expq.size() > 0) compare(expq.pop_front());
            else compare(exp_at(0));
        end
    end

    // driver: start pulse, then a start pattern during cycles 1..15 (must be ignored, R2)
    task automatic run_mm(input logic [14:0] noise);
        @(negedge clk);
        start = 1'b1;
        for (int t = 0; t <= 16; t++) expq.push_back(exp_at(t));
        for (int i = 1; i <= 16; i++) begin
            @(negedge clk);
            start = (i <= 15) ? noise[i-1] : 1'b0;
        end
        start = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: outputs during reset
        #1;
        compare(exp_at(0));
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        #1;
        // R1: first cycle after release
        compare(exp_at(0));
        mon_on = 1'b1;
        repeat (3) @(negedge clk);
        run_mm(15'h0000);               // clean pulse
        run_mm(15'h7fff);               // start held through the whole run
        run_mm(15'h5555);               // toggling start
        run_mm(15'h4000);               // start only in the done cycle
        repeat (4) @(negedge clk);
        run_mm(15'h2a2a);
        repeat (3) @(negedge clk);
        mon_on = 1'b0;
        if (!finished) begin
            finished = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        #(PERIOD * 20000);
        if (!finished) begin
            finished = 1'b1;
            n_bad++;
            $display("FAIL watchdog expired act=running exp=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

endmodule